// File: doc/BRIEF.md
# Per-Processor Soft Interrupt Pending Bank

This block holds one 32-bit interrupt pending word for each processor in a small multiprocessor system and turns the upper part of each word into a leveled interrupt request for that processor. Software reaches the words through a word-addressed register window. Each processor owns one 4 KiB page of that window, and the page number in the address picks the processor. Within a page, one word reads back the pending bits, one word clears bits on a write of ones, and one word sets bits on a write of ones.

Two hardware sources also change the pending words. A forwarded system interrupt event sets or clears the bit whose index equals the forwarded level, in the word of the processor named with the event. Each processor also has a local timer input, whose rising edge sets one fixed bit and whose falling edge clears it. For each processor a priority encoder looks only at bits 17 to 31. When that processor has no request outstanding, the block raises a request carrying the level of the highest such bit. The request and its level are then held until the processor pulses its acknowledge input.

Top module: `softint_bank`

## Requirements
- R1: After reset every pending word reads zero and every irq_valid is low.
- R2: The processor is bus_addr[13:12] and the word is bus_addr[3:2]. Word 0 drives bus_rdata with the addressed processor's pending word. Words 1, 2 and 3 read as zero.
- R3: A bus write to word 1 clears, in the addressed processor's word only, each bit that is one in bus_wdata.
- R4: A bus write to word 2 sets, in the addressed processor's word only, each bit that is one in bus_wdata.
- R5: A bus write to word 3 changes no pending word.
- R6: A cycle with fwd_valid high sets (fwd_set=1) or clears (fwd_set=0) bit fwd_level of processor fwd_cpu's word and no other bit.
- R7: A rising edge on tmr_in[c] sets bit 14 of processor c's word and a falling edge clears it. A steady tmr_in has no effect.
- R8: When a set and a clear of the same bit fall in the same cycle, from any mix of sources, the bit ends up set.
- R9: When irq_valid[c] is low and bits 17..31 of word c are not all zero, irq_valid[c] rises at the next clock edge and its level equals the highest such bit index minus 16 (1..15). Bits 0..16 never raise a request.
- R10: While irq_valid[c] is high and irq_ack[c] is low, irq_valid[c] stays high and its level stays unchanged, whatever happens to the pending word.
- R11: An irq_ack[c] pulse while the request is high drops irq_valid[c] at that edge. If delivery bits are still pending, the request rises again one cycle later with the new level. An acknowledge while no request is high has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Register access strobe |
| bus_write | input | 1 | 1 = write access |
| bus_addr | input | 16 | Byte address: page selects the processor, bits 3:2 select the word |
| bus_wdata | input | 32 | Write data (bit mask for the clear and set words) |
| bus_rdata | output | 32 | Read data for the current address |
| fwd_valid | input | 1 | Forwarded system interrupt event strobe |
| fwd_set | input | 1 | 1 = set the bit, 0 = clear it |
| fwd_cpu | input | 2 | Target processor of the forwarded event |
| fwd_level | input | 4 | Bit index to set or clear |
| tmr_in | input | 4 | Local timer line per processor |
| irq_ack | input | 4 | Per-processor acknowledge pulse |
| irq_valid | output | 4 | Per-processor interrupt request |
| irq_level | output | 16 | Per-processor request level, 4 bits each, processor c at [4c+3:4c] |

## Verification
A software clear can land on a bit in the same cycle that the timer edge, the forwarded event or a software set also drives it. The bench provokes this by driving a clear on the timer bit in the same cycle as a timer rising edge, and by pairing a forwarded set with a clear of that bit, and a forwarded clear with a software set. In each case it reads the word back and expects the bit to be set. The other pairing is a new higher-priority pending bit that arrives while a request is outstanding. The bench checks that the held level does not change, and that after the acknowledge the request drops for exactly one cycle and then returns with the new level.

// File: rtl/softint_pkg.sv
package softint_pkg;
   // Word offsets inside one processor page (bits 3:2 of the address)
   typedef enum logic [1:0] {
      WD_PEND = 2'd0,
      WD_CLR  = 2'd1,
      WD_SET  = 2'd2,
      WD_NONE = 2'd3
   } word_e;
endpackage

// File: rtl/softint_decode.sv
module softint_decode
   import softint_pkg::*;
#(
   parameter int NUM_CPU  = 4,
   parameter int ADDR_W   = 16,
   parameter int DATA_W   = 32,
   parameter int PAGE_LSB = 12,
   localparam int CPU_W   = $clog2(NUM_CPU)
) (
   input  logic                             bus_valid,
   input  logic                             bus_write,
   input  logic [ADDR_W-1:0]                bus_addr,
   input  logic [DATA_W-1:0]                bus_wdata,
   output logic [CPU_W-1:0]                 cpu_sel,
   output word_e                            word_sel,
   output logic [NUM_CPU-1:0][DATA_W-1:0]   sw_clr,
   output logic [NUM_CPU-1:0][DATA_W-1:0]   sw_set
);
   logic unused_addr_bits;

   assign cpu_sel  = bus_addr[PAGE_LSB +: CPU_W];
   assign word_sel = word_e'(bus_addr[3:2]);
   assign unused_addr_bits = ^bus_addr;

   for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
      logic hit;
      assign hit       = bus_valid && bus_write && (cpu_sel == CPU_W'(c));
      assign sw_clr[c] = (hit && word_sel == WD_CLR) ? bus_wdata : '0;
      assign sw_set[c] = (hit && word_sel == WD_SET) ? bus_wdata : '0;
   end
endmodule

// File: rtl/softint_cell.sv
module softint_cell #(
   parameter int DATA_W    = 32,
   parameter int TIMER_BIT = 14
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] sw_clr,
   input  logic [DATA_W-1:0] sw_set,
   input  logic [DATA_W-1:0] hw_clr,
   input  logic [DATA_W-1:0] hw_set,
   input  logic              tmr_in,
   output logic [DATA_W-1:0] pend_q
);
   logic              tmr_d;
   logic [DATA_W-1:0] tmr_rise_m;
   logic [DATA_W-1:0] tmr_fall_m;
   logic [DATA_W-1:0] clr_all;
   logic [DATA_W-1:0] set_all;
   logic [DATA_W-1:0] pend_d;

   assign tmr_rise_m = (tmr_in && !tmr_d) ? (DATA_W'(1) << TIMER_BIT) : '0;
   assign tmr_fall_m = (!tmr_in && tmr_d) ? (DATA_W'(1) << TIMER_BIT) : '0;
   assign clr_all    = sw_clr | hw_clr | tmr_fall_m;
   assign set_all    = sw_set | hw_set | tmr_rise_m;
   // clears first, sets last: a set wins a same-cycle collision
   assign pend_d     = (pend_q & ~clr_all) | set_all;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tmr_d  <= 1'b0;
         pend_q <= '0;
      end else begin
         tmr_d  <= tmr_in;
         pend_q <= pend_d;
      end
   end
endmodule

// File: rtl/softint_prio.sv
module softint_prio #(
   parameter int DATA_W  = 32,
   parameter int SOFT_LO = 17,
   localparam int LVL_W  = $clog2(DATA_W - SOFT_LO + 1)
) (
   input  logic [DATA_W-1:0] pend,
   output logic              any,
   output logic [LVL_W-1:0]  level
);
   always_comb begin
      any   = 1'b0;
      level = '0;
      for (int i = SOFT_LO; i < DATA_W; i++) begin
         if (pend[i]) begin
            any   = 1'b1;
            level = LVL_W'(i - SOFT_LO + 1);
         end
      end
   end
endmodule

// File: rtl/softint_deliver.sv
module softint_deliver #(
   parameter int LVL_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             any,
   input  logic [LVL_W-1:0] level,
   input  logic             ack,
   output logic             irq_valid,
   output logic [LVL_W-1:0] irq_level
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_valid <= 1'b0;
         irq_level <= '0;
      end else if (irq_valid) begin
         if (ack) begin
            irq_valid <= 1'b0;
            irq_level <= '0;
         end
      end else if (any) begin
         irq_valid <= 1'b1;
         irq_level <= level;
      end
   end
endmodule

// File: rtl/softint_bank.sv
module softint_bank
   import softint_pkg::*;
#(
   parameter int NUM_CPU   = 4,
   parameter int ADDR_W    = 16,
   parameter int DATA_W    = 32,
   parameter int PAGE_LSB  = 12,
   parameter int SOFT_LO   = 17,
   parameter int TIMER_BIT = 14,
   parameter int FWD_W     = 4,
   localparam int CPU_W    = $clog2(NUM_CPU),
   localparam int LVL_W    = $clog2(DATA_W - SOFT_LO + 1)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     bus_valid,
   input  logic                     bus_write,
   input  logic [ADDR_W-1:0]        bus_addr,
   input  logic [DATA_W-1:0]        bus_wdata,
   output logic [DATA_W-1:0]        bus_rdata,
   input  logic                     fwd_valid,
   input  logic                     fwd_set,
   input  logic [CPU_W-1:0]         fwd_cpu,
   input  logic [FWD_W-1:0]         fwd_level,
   input  logic [NUM_CPU-1:0]       tmr_in,
   input  logic [NUM_CPU-1:0]       irq_ack,
   output logic [NUM_CPU-1:0]       irq_valid,
   output logic [NUM_CPU*LVL_W-1:0] irq_level
);
   // elaboration-time parameter checks
   if (NUM_CPU < 2 || (1 << CPU_W) != NUM_CPU) begin : g_bad_cpu
      $error("NUM_CPU must be a power of two, at least 2");
   end
   if (ADDR_W < PAGE_LSB + CPU_W || PAGE_LSB < 4) begin : g_bad_addr
      $error("ADDR_W/PAGE_LSB cannot hold the processor page field");
   end
   if (SOFT_LO < 1 || SOFT_LO >= DATA_W) begin : g_bad_soft
      $error("SOFT_LO must lie inside the data word");
   end
   if (TIMER_BIT >= DATA_W || (1 << FWD_W) > DATA_W) begin : g_bad_bits
      $error("timer bit or forwarded level range exceeds the data word");
   end

   logic [CPU_W-1:0]               cpu_sel;
   word_e                          word_sel;
   logic [NUM_CPU-1:0][DATA_W-1:0] sw_clr;
   logic [NUM_CPU-1:0][DATA_W-1:0] sw_set;
   logic [NUM_CPU-1:0][DATA_W-1:0] pend_q;
   logic [DATA_W-1:0]              fwd_mask;

   assign fwd_mask = DATA_W'(1) << fwd_level;

   softint_decode #(
      .NUM_CPU (NUM_CPU),
      .ADDR_W  (ADDR_W),
      .DATA_W  (DATA_W),
      .PAGE_LSB(PAGE_LSB)
   ) u_dec (
      .bus_valid(bus_valid),
      .bus_write(bus_write),
      .bus_addr (bus_addr),
      .bus_wdata(bus_wdata),
      .cpu_sel  (cpu_sel),
      .word_sel (word_sel),
      .sw_clr   (sw_clr),
      .sw_set   (sw_set)
   );

   for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
      logic              fwd_hit;
      logic [DATA_W-1:0] hw_set;
      logic [DATA_W-1:0] hw_clr;
      logic              any;
      logic [LVL_W-1:0]  level;

      assign fwd_hit = fwd_valid && (fwd_cpu == CPU_W'(c));
      assign hw_set  = (fwd_hit &&  fwd_set) ? fwd_mask : '0;
      assign hw_clr  = (fwd_hit && !fwd_set) ? fwd_mask : '0;

      softint_cell #(
         .DATA_W   (DATA_W),
         .TIMER_BIT(TIMER_BIT)
      ) u_cell (
         .clk   (clk),
         .rst_n (rst_n),
         .sw_clr(sw_clr[c]),
         .sw_set(sw_set[c]),
         .hw_clr(hw_clr),
         .hw_set(hw_set),
         .tmr_in(tmr_in[c]),
         .pend_q(pend_q[c])
      );

      softint_prio #(
         .DATA_W (DATA_W),
         .SOFT_LO(SOFT_LO)
      ) u_prio (
         .pend (pend_q[c]),
         .any  (any),
         .level(level)
      );

      softint_deliver #(
         .LVL_W(LVL_W)
      ) u_dlv (
         .clk      (clk),
         .rst_n    (rst_n),
         .any      (any),
         .level    (level),
         .ack      (irq_ack[c]),
         .irq_valid(irq_valid[c]),
         .irq_level(irq_level[c*LVL_W +: LVL_W])
      );
   end

   assign bus_rdata = (word_sel == WD_PEND) ? pend_q[cpu_sel] : '0;
endmodule

// File: rtl/softint_bank_chk.sv
module softint_bank_chk #(
   parameter int NUM_CPU = 4,
   parameter int LVL_W   = 4
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic [NUM_CPU-1:0]       irq_ack,
   input logic [NUM_CPU-1:0]       irq_valid,
   input logic [NUM_CPU*LVL_W-1:0] irq_level
);
   // R1: reset leaves no request standing
   assert_reset_idle_R1: assert property (@(posedge clk)
      !rst_n |=> (irq_valid == '0));

   for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
      // R9: a raised request always carries a delivery level of 1 or more
      assert_level_nonzero_R9: assert property (@(posedge clk) disable iff (!rst_n)
         irq_valid[c] |-> (irq_level[c*LVL_W +: LVL_W] != '0));

      // R10: request and level held until acknowledged
      assert_hold_until_ack_R10: assert property (@(posedge clk) disable iff (!rst_n)
         (irq_valid[c] && !irq_ack[c]) |=>
            (irq_valid[c] && $stable(irq_level[c*LVL_W +: LVL_W])));

      // R11: acknowledge drops an active request
      assert_ack_drops_R11: assert property (@(posedge clk) disable iff (!rst_n)
         (irq_valid[c] && irq_ack[c]) |=> !irq_valid[c]);
   end
endmodule

bind softint_bank softint_bank_chk #(
   .NUM_CPU(NUM_CPU),
   .LVL_W  (LVL_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .irq_ack  (irq_ack),
   .irq_valid(irq_valid),
   .irq_level(irq_level)
);

// File: tb/sim_softint_bank.sv
`timescale 1ns/10ps
module sim_softint_bank;
   localparam int NC = 4;
   localparam int LW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_valid = 1'b0;
   logic          bus_write = 1'b0;
   logic [15:0]   bus_addr = '0;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;
   logic          fwd_valid = 1'b0;
   logic          fwd_set = 1'b0;
   logic [1:0]    fwd_cpu = '0;
   logic [3:0]    fwd_level = '0;
   logic [NC-1:0] tmr_in = '0;
   logic [NC-1:0] irq_ack = '0;
   logic [NC-1:0] irq_valid;
   logic [NC*LW-1:0] irq_level;

   int n_chk = 0;
   int n_err = 0;
   logic [31:0] exp_p [NC];
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   softint_bank u0 (
      .clk(clk), .rst_n(rst_n),
      .bus_valid(bus_valid), .bus_write(bus_write),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .fwd_valid(fwd_valid), .fwd_set(fwd_set), .fwd_cpu(fwd_cpu),
      .fwd_level(fwd_level), .tmr_in(tmr_in), .irq_ack(irq_ack),
      .irq_valid(irq_valid), .irq_level(irq_level)
   );

   task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] expv);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", req, act, expv);
      end
   endtask

   function automatic logic [3:0] exp_lvl(logic [31:0] p);
      logic [3:0] l = '0;
      for (int i = 17; i < 32; i++) if (p[i]) l = 4'(i - 16);
      return l;
   endfunction

   // starts and ends at a falling edge; one rising edge in between
   task automatic bus_wr(int cpu, int word, logic [31:0] d);
      bus_addr  = 16'((cpu << 12) | (word << 2));
      bus_wdata = d;
      bus_valid = 1'b1;
      bus_write = 1'b1;
      @(negedge clk);
      bus_valid = 1'b0;
      bus_write = 1'b0;
      if (word == 1) exp_p[cpu] &= ~d;
      if (word == 2) exp_p[cpu] |= d;
   endtask

   task automatic check_pend(string req);
      for (int c = 0; c < NC; c++) begin
         bus_addr = 16'(c << 12);
         #0.1;
         chk(bus_rdata === exp_p[c], req, bus_rdata, exp_p[c]);
      end
   endtask

   task automatic check_irq(int c, bit v, logic [3:0] l, string req);
      chk(irq_valid[c] === v, req, 32'(irq_valid[c]), 32'(v));
      if (v) chk(irq_level[c*LW +: LW] === l, req, 32'(irq_level[c*LW +: LW]), 32'(l));
   endtask

   task automatic ack_pulse(int c);
      irq_ack[c] = 1'b1;
      @(negedge clk);
      irq_ack[c] = 1'b0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   endtask

   initial begin
      #(200000 * 5);
      n_err++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      finish_run();
   end

   initial begin
      for (int c = 0; c < NC; c++) exp_p[c] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      check_pend("R1");
      chk(irq_valid === '0, "R1", 32'(irq_valid), 32'd0);

      // R4 R3 R9 R11: single-bit sweep over every processor and bit
      for (int c = 0; c < NC; c++) begin
         for (int b = 0; b < 32; b++) begin
            bus_wr(c, 2, 32'd1 << b);
            check_pend("R4");
            @(negedge clk);
            for (int o = 0; o < NC; o++)
               check_irq(o, (o == c) && (b >= 17), 4'(b - 16), "R9");
            bus_wr(c, 1, 32'd1 << b);
            check_pend("R3");
            if (b >= 17) begin
               check_irq(c, 1'b1, 4'(b - 16), "R10");
               ack_pulse(c);
               check_irq(c, 1'b0, '0, "R11");
               @(negedge clk);
               check_irq(c, 1'b0, '0, "R11");
            end
         end
      end

      // R4 R3 R9: multi-bit patterns
      for (int k = 1; k <= 8; k++) begin
         automatic int c = k % NC;
         automatic logic [31:0] d = 32'h9E3779B9 * k;
         automatic logic [31:0] d2 = d ^ (d << 3);
         bus_wr(c, 2, d);
         check_pend("R4");
         @(negedge clk);
         check_irq(c, exp_lvl(exp_p[c]) != 0, exp_lvl(exp_p[c]), "R9");
         bus_wr(c, 1, d2);
         check_pend("R3");
         bus_wr(c, 1, 32'hFFFF_FFFF);
         ack_pulse(c);
         @(negedge clk);
         check_irq(c, 1'b0, '0, "R11");
      end

      // R2 R5: unused word reads zero and ignores writes
      bus_wr(2, 2, 32'h0000_F0F0);
      bus_wr(2, 3, 32'hFFFF_FFFF);
      check_pend("R5");
      bus_wr(2, 3, 32'h0000_0000);
      check_pend("R5");
      for (int w = 1; w < 4; w++) begin
         bus_addr = 16'((2 << 12) | (w << 2));
         #0.1;
         chk(bus_rdata === 32'd0, "R2", bus_rdata, 32'd0);
      end
      bus_addr = 16'((2 << 12) | 16'h0FF0);   // in-page bits above word field ignored
      #0.1;
      chk(bus_rdata === exp_p[2], "R2", bus_rdata, exp_p[2]);
      bus_wr(2, 1, 32'hFFFF_FFFF);

      // R6: forwarded events
      fwd_valid = 1'b1; fwd_set = 1'b1; fwd_cpu = 2'd3; fwd_level = 4'd9;
      @(negedge clk);
      fwd_valid = 1'b0;
      exp_p[3] |= 32'd1 << 9;
      check_pend("R6");
      fwd_valid = 1'b1; fwd_set = 1'b1; fwd_cpu = 2'd0; fwd_level = 4'd15;
      @(negedge clk);
      fwd_valid = 1'b0;
      exp_p[0] |= 32'd1 << 15;
      check_pend("R6");
      fwd_valid = 1'b1; fwd_set = 1'b0; fwd_cpu = 2'd3; fwd_level = 4'd9;
      @(negedge clk);
      fwd_valid = 1'b0;
      exp_p[3] &= ~(32'd1 << 9);
      check_pend("R6");
      bus_wr(0, 1, 32'hFFFF_FFFF);

      // R7: timer edges
      tmr_in[1] = 1'b1;
      @(negedge clk);
      exp_p[1] |= 32'd1 << 14;
      check_pend("R7");
      bus_wr(1, 1, 32'd1 << 14);
      repeat (3) @(negedge clk);
      check_pend("R7");
      bus_wr(1, 2, 32'd1 << 14);
      tmr_in[1] = 1'b0;
      @(negedge clk);
      exp_p[1] &= ~(32'd1 << 14);
      check_pend("R7");
      repeat (2) @(negedge clk);
      check_pend("R7");

      // R8: same-cycle set and clear of one bit
      tmr_in[1] = 1'b1;
      bus_wr(1, 1, 32'd1 << 14);
      exp_p[1] |= 32'd1 << 14;
      check_pend("R8");
      fwd_valid = 1'b1; fwd_set = 1'b1; fwd_cpu = 2'd2; fwd_level = 4'd5;
      bus_wr(2, 1, 32'd1 << 5);
      fwd_valid = 1'b0;
      exp_p[2] |= 32'd1 << 5;
      check_pend("R8");
      fwd_valid = 1'b1; fwd_set = 1'b0; fwd_cpu = 2'd2; fwd_level = 4'd5;
      bus_wr(2, 2, 32'd1 << 5);
      fwd_valid = 1'b0;
      check_pend("R8");
      tmr_in[1] = 1'b0;
      @(negedge clk);
      exp_p[1] &= ~(32'd1 << 14);
      bus_wr(2, 1, 32'hFFFF_FFFF);
      check_pend("R8");

      // R10 R11: hold level, drop on ack, re-raise with new level
      bus_wr(0, 2, 32'd1 << 20);
      @(negedge clk);
      check_irq(0, 1'b1, 4'd4, "R9");
      bus_wr(0, 2, 32'd1 << 30);
      check_irq(0, 1'b1, 4'd4, "R10");
      @(negedge clk);
      check_irq(0, 1'b1, 4'd4, "R10");
      ack_pulse(0);
      check_irq(0, 1'b0, '0, "R11");
      @(negedge clk);
      check_irq(0, 1'b1, 4'd14, "R11");
      bus_wr(0, 1, 32'hFFFF_FFFF);
      ack_pulse(0);
      @(negedge clk);
      check_irq(0, 1'b0, '0, "R11");

      // R11: acknowledge while idle is ignored; then top level 15
      ack_pulse(3);
      check_irq(3, 1'b0, '0, "R11");
      bus_wr(3, 2, 32'h8000_0000);
      @(negedge clk);
      check_irq(3, 1'b1, 4'd15, "R9");
      check_pend("R4");

      finish_run();
   end
endmodule